// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This block keeps the status byte of a serial EEPROM and decides, address by address, whether the array may be programmed. It also decides whether the status byte itself may be rewritten. A command engine sits beside it and sends one-cycle strobes: one when a full enable or disable opcode has arrived, and one when a status-write data byte has been captured. The engine also pulses a tick for every further serial bit received inside the same chip-select frame. The block also reads the chip-select level, the protect-pin level, the busy flag of the write timer and a completion pulse from that timer. The protect pin allows writes when high. All inputs are already synchronous to `clk`.

Effects are held back until chip select rises. An enable or disable only takes hold if no extra bit followed its opcode. A status write is committed at that edge unless the protect pin fell while the frame was still open. After the commit, the pin no longer matters. The protect fields survive any number of chip-select frames. This retention stands in for non-volatile cells, which are not part of this block.

Top module: `eeprom_status_guard`

## Requirements
- R1: `status_o` carries the protect-enable flag in bit 7, zeros in bits 6..4, block field high bit in 3, low bit in 2, the write latch in bit 1 and `busy_i` in bit 0. While `busy_i` is 1 the byte reads 0xFF.
- R2: After reset the status byte reads 0x00, and both permits are 0.
- R3: An enable strobe sets the write latch when chip select next rises. Any `bit_tick_i` after the strobe in the same frame leaves the latch unchanged.
- R4: A disable strobe clears the write latch when chip select next rises, under the same extra-bit rule as R3.
- R5: A `wr_done_i` pulse clears the write latch on the next clock.
- R6: A status write changes only bits 7, 3 and 2, taken from the data byte in those positions. It needs the write latch at capture and takes effect when chip select rises.
- R7: When the protect-enable flag is 1 and the protect pin is low, `sr_wr_ok_o` is 0 and a status write has no effect.
- R8: A protect-pin fall while chip select is low discards a pending status write. A fall after chip select has risen does not undo a committed write.
- R9: The block field selects the protected range: 00 protects nothing, 01 the top quarter of the address space, 10 the top half, and 11 all of it. `arr_wr_ok_o` is 0 for any address inside that range.
- R10: Outside the protected range, `arr_wr_ok_o` equals the write latch, whatever the protect-enable flag and the pin are.
- R11: While `busy_i` is 1, the enable, disable and status-write strobes are ignored.
- R12: Chip-select frames that carry no strobes leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip-select level, active low |
| bit_tick_i | input | 1 | Pulse for each serial bit received after an opcode |
| op_wren_i | input | 1 | Enable opcode received |
| op_wrdi_i | input | 1 | Disable opcode received |
| op_wrsr_i | input | 1 | Status-write data byte captured |
| wrsr_data_i | input | 8 | Status-write data byte |
| wr_done_i | input | 1 | Internal write cycle finished |
| busy_i | input | 1 | Internal write cycle in progress |
| wp_pin_i | input | 1 | Protect-pin level; low requests protection |
| arr_addr_i | input | ADDR_W | Array address to be judged |
| status_o | output | 8 | Status byte for reads |
| arr_wr_ok_o | output | 1 | Array write allowed at `arr_addr_i` |
| sr_wr_ok_o | output | 1 | Status write allowed now |

## Verification
A wrong write latch shows up on the very next cycle in three places: bit 1 of `status_o`, `arr_wr_ok_o` at an unprotected address, and `sr_wr_ok_o`. A latch that was set by a frame carrying extra bits, or that was not cleared by a completion pulse, is therefore caught one clock after the chip-select edge or the pulse. A corrupted block field moves the boundary where `arr_wr_ok_o` drops. This is exposed by probing the addresses on either side of each range limit. A pending status write that survives a pin fall appears in bits 7..2 right after chip select rises.

// File: rtl/esg_pkg.sv
package esg_pkg;
    localparam int SR_W      = 8;
    localparam int SR_BIT_PE = 7;
    localparam int SR_BIT_B1 = 3;
    localparam int SR_BIT_B0 = 2;
    localparam int SR_BIT_WL = 1;

    typedef struct packed {
        logic       wel;
        logic       pe;
        logic [1:0] blk;
        logic       en_arm;
        logic       dis_arm;
        logic       sr_arm;
        logic       sr_pe;
        logic [1:0] sr_blk;
    } esg_state_t;

    localparam esg_state_t ESG_RESET = '0;

    function automatic logic [SR_W-1:0] pack_status(input logic pe, input logic [1:0] blk,
                                                    input logic wel, input logic busy);
        logic [SR_W-1:0] s;
        s            = '0;
        s[SR_BIT_PE] = pe;
        s[SR_BIT_B1] = blk[1];
        s[SR_BIT_B0] = blk[0];
        s[SR_BIT_WL] = wel;
        s[0]         = busy;
        return busy ? {SR_W{1'b1}} : s;
    endfunction
endpackage

// File: rtl/esg_edge.sv
module esg_edge #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] lvl_d, lvl_q;

    always_comb begin
        lvl_d = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= {W{RST_VAL}};
        else        lvl_q <= lvl_d;
    end

    assign rise_o = sig_i & ~lvl_q;
    assign fall_o = ~sig_i & lvl_q;
endmodule

// File: rtl/esg_region_decode.sv
module esg_region_decode #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        blk_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        unique case (blk_i)
            2'b00:   locked_o = 1'b0;
            2'b01:   locked_o = addr_i[TOP] & addr_i[TOP-1];
            2'b10:   locked_o = addr_i[TOP];
            default: locked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
    import esg_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              bit_tick_i,
    input  logic              op_wren_i,
    input  logic              op_wrdi_i,
    input  logic              op_wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              wr_done_i,
    input  logic              busy_i,
    input  logic              wp_pin_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    output logic [7:0]        status_o,
    output logic              arr_wr_ok_o,
    output logic              sr_wr_ok_o
);
    esg_state_t st_d, st_q;
    logic       cs_rise, cs_fall, wp_rise, wp_fall, locked;

    esg_edge #(.W(1), .RST_VAL(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(cs_n_i), .rise_o(cs_rise), .fall_o(cs_fall)
    );

    esg_edge #(.W(1), .RST_VAL(1'b1)) u_wp_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(wp_pin_i), .rise_o(wp_rise), .fall_o(wp_fall)
    );

    esg_region_decode #(.ADDR_W(ADDR_W)) u_region (
        .blk_i(st_q.blk), .addr_i(arr_addr_i), .locked_o(locked)
    );

    assign sr_wr_ok_o  = st_q.wel & ~(st_q.pe & ~wp_pin_i);
    assign arr_wr_ok_o = st_q.wel & ~locked;
    assign status_o    = pack_status(st_q.pe, st_q.blk, st_q.wel, busy_i);

    always_comb begin
        st_d = st_q;
        if (cs_fall) begin
            st_d.en_arm  = 1'b0;
            st_d.dis_arm = 1'b0;
            st_d.sr_arm  = 1'b0;
        end
        if (bit_tick_i) begin
            st_d.en_arm  = 1'b0;
            st_d.dis_arm = 1'b0;
        end
        if (!busy_i) begin
            if (op_wren_i) begin
                st_d.en_arm  = 1'b1;
                st_d.dis_arm = 1'b0;
            end
            if (op_wrdi_i) begin
                st_d.dis_arm = 1'b1;
                st_d.en_arm  = 1'b0;
            end
            if (op_wrsr_i && sr_wr_ok_o) begin
                st_d.sr_arm = 1'b1;
                st_d.sr_pe  = wrsr_data_i[SR_BIT_PE];
                st_d.sr_blk = {wrsr_data_i[SR_BIT_B1], wrsr_data_i[SR_BIT_B0]};
            end
        end
        if (wp_fall && !cs_n_i) st_d.sr_arm = 1'b0;
        if (cs_rise) begin
            if (st_q.en_arm)  st_d.wel = 1'b1;
            if (st_q.dis_arm) st_d.wel = 1'b0;
            if (st_q.sr_arm) begin
                st_d.pe  = st_q.sr_pe;
                st_d.blk = st_q.sr_blk;
            end
            st_d.en_arm  = 1'b0;
            st_d.dis_arm = 1'b0;
            st_d.sr_arm  = 1'b0;
        end
        if (wr_done_i) st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ESG_RESET;
        else        st_q <= st_d;
    end

    AST_WEL_SET_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.wel) |-> $past(cs_rise)); // R3
    AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done_i |=> !st_q.wel); // R5
    AST_FIELDS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !cs_rise) |=> $stable({st_q.pe, st_q.blk})); // R11
    AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.blk == 2'b11) |-> !arr_wr_ok_o); // R9
    AST_SR_ARM_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sr_arm) |-> $past(st_q.wel)); // R6
    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (status_o[6:4] == 3'b000)); // R1
    AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pe && !wp_pin_i && !wp_rise) |-> !sr_wr_ok_o); // R7
endmodule

// File: tb/eeprom_status_guard_tb.sv
module eeprom_status_guard_tb;
    localparam int ADDR_W = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, tick = 1'b0, wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
    logic [7:0] wdata = '0;
    logic done = 1'b0, busy = 1'b0, wp = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] status;
    logic arr_ok, sr_ok;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    eeprom_status_guard #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .bit_tick_i(tick),
        .op_wren_i(wren), .op_wrdi_i(wrdi), .op_wrsr_i(wrsr), .wrsr_data_i(wdata),
        .wr_done_i(done), .busy_i(busy), .wp_pin_i(wp), .arr_addr_i(addr),
        .status_o(status), .arr_wr_ok_o(arr_ok), .sr_wr_ok_o(sr_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_low();  @(negedge clk) cs_n = 1'b0; @(negedge clk); endtask
    task automatic cs_high(); @(negedge clk) cs_n = 1'b1; @(negedge clk); endtask

    task automatic frame_en(input bit enable, input int extra);
        cs_low();
        @(negedge clk) begin wren = enable; wrdi = !enable; end
        @(negedge clk) begin wren = 1'b0; wrdi = 1'b0; end
        for (int i = 0; i < extra; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        cs_high();
    endtask

    task automatic frame_sr(input logic [7:0] d, input bit drop_pin);
        cs_low();
        @(negedge clk) begin wrsr = 1'b1; wdata = d; end
        @(negedge clk) wrsr = 1'b0;
        if (drop_pin) begin
            @(negedge clk) wp = 1'b0;
            @(negedge clk);
        end
        cs_high();
    endtask

    task automatic probe(input logic [ADDR_W-1:0] a, input logic exp, input string req);
        @(negedge clk) addr = a;
        #1 chk(req, arr_ok, exp);
    endtask

    task automatic pulse_done();
        @(negedge clk) done = 1'b1;
        @(negedge clk) done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 status", status, 8'h00);
        chk("R2 array permit", arr_ok, 0);
        chk("R2 status permit", sr_ok, 0);
    endtask

    task automatic t_latch();
        frame_en(1, 0);
        chk("R3 enable", status, 8'h02);
        probe(11'h000, 1, "R10 unprotected permit");
        frame_en(0, 0);
        chk("R4 disable", status, 8'h00);
        frame_en(1, 1);
        chk("R3 extra bit cancels", status, 8'h00);
        frame_en(1, 0);
        frame_en(0, 2);
        chk("R4 extra bit cancels", status, 8'h02);
    endtask

    task automatic t_status_write();
        frame_sr(8'hFF, 0);
        chk("R6 only bits 7,3,2", status, 8'h8E);
        probe(11'h000, 0, "R9 full low");
        probe(11'h7FF, 0, "R9 full high");
        pulse_done();
        chk("R5 done clears latch", status, 8'h8C);
        frame_sr(8'h00, 0);
        chk("R6 needs latch", status, 8'h8C);
    endtask

    task automatic t_ranges();
        frame_en(1, 0);
        frame_sr(8'h84, 0);
        chk("R6 quarter", status, 8'h86);
        probe(11'h5FF, 1, "R9 below quarter");
        probe(11'h600, 0, "R9 quarter start");
        frame_sr(8'h08, 0);
        chk("R6 half", status, 8'h0A);
        probe(11'h3FF, 1, "R9 below half");
        probe(11'h400, 0, "R9 half start");
        frame_sr(8'h80, 0);
        chk("R6 none", status, 8'h82);
        probe(11'h7FF, 1, "R9 none top");
    endtask

    task automatic t_pin_lock();
        @(negedge clk) wp = 1'b0;
        #1 chk("R7 permit low", sr_ok, 0);
        frame_sr(8'h0C, 0);
        chk("R7 write blocked", status, 8'h82);
        probe(11'h7FF, 1, "R10 pin ignored for array");
        @(negedge clk) wp = 1'b1;
        #1 chk("R7 permit back", sr_ok, 1);
    endtask

    task automatic t_cancel();
        frame_sr(8'h8C, 1);
        chk("R8 fall cancels", status, 8'h82);
        @(negedge clk) wp = 1'b1;
        frame_sr(8'h88, 0);
        @(negedge clk) wp = 1'b0;
        @(negedge clk);
        chk("R8 fall after commit", status, 8'h8A);
    endtask

    task automatic t_busy();
        @(negedge clk) busy = 1'b1;
        #1 chk("R1 busy reads FF", status, 8'hFF);
        frame_en(0, 0);
        @(negedge clk) wp = 1'b1;
        frame_sr(8'h00, 0);
        @(negedge clk) busy = 1'b0;
        #1 chk("R11 strobes ignored", status, 8'h8A);
        pulse_done();
        chk("R5 done", status, 8'h88);
    endtask

    task automatic t_retain();
        for (int i = 0; i < 3; i++) begin
            cs_low();
            cs_high();
        end
        chk("R12 retained", status, 8'h88);
        chk("R12 permit", sr_ok, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_status_write();
        t_ranges();
        t_pin_lock();
        t_cancel();
        t_busy();
        t_retain();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule